// File: doc/BRIEF.md
# Trim Fuse Refresh Scanner

This block keeps a set of shadow registers in step with a small array of factory-programmed trim fuses. A scan counter walks the fuse array without stopping, one position per crystal clock, and a full pass takes 45 clocks before it wraps and begins again. Each of the seven readable trims has its own slot in the pass. In that slot its fuse value is copied into its shadow register. The shadows drive the trimmed hardware directly through a flat output bus. The same shadows are also visible to software through a select/data register pair.

Software writes a trim number from 1 to 7 into the select register and then reads that trim from the data port. When it has finished, it writes 0 to deselect. The fuse array is a bus of fixed input values, and the block provides no way to change it. A flag tells the rest of the chip when a full pass has finished since reset or since the last restart. The restart input is pulsed on a wake from sleep. It forces a fresh full pass and leaves the shadows holding their current values until each one is sampled again.

Top module: `trim_scan`

## Requirements
- R1: While reset is asserted, every shadow (and so `trim_out`) is 0x00, `pass_done` is 0, `sel_q` is 0 and `rd_data` is 0x00.
- R2: Trim k (k = 1..7) is sampled in scan slot k-1. After reset is released or a restart is taken, the first clock edge loads trim 1, and the seventh edge has loaded all seven trims.
- R3: A shadow changes only at the clock edge of its own slot. A change on its fuse input that arrives after that slot shows up one full pass later, and other shadows are unaffected.
- R4: `trim_out` carries trim k in bits [8k-1 : 8(k-1)], and `fuse_vals` uses the same packing.
- R5: A clock edge with `sel_we` high loads `sel_wdata` into the select register. For a select value from 1 to 7, `rd_data` shows that trim's shadow in the same cycle.
- R6: A select value of 0, or any value above 7, gives `rd_data` = 0x00.
- R7: A pass is 45 clocks long. `pass_done` goes high at the end of the 45th clock edge after reset or restart and then stays high while the scan keeps looping.
- R8: A clock edge with `restart` high clears `pass_done` and puts the scan back to slot 0 without sampling. The shadows keep their values, so the next edge reloads trim 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; one fuse slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Forces a new full pass (wake) |
| fuse_vals | input | 56 | Fuse array, trim k in bits [8k-1:8(k-1)] |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 4 | Trim number to select (0 deselects) |
| sel_q | output | 4 | Current select register value |
| rd_data | output | 8 | Selected trim, or 0x00 if none |
| trim_out | output | 56 | All shadows, feeding trimmed hardware |
| pass_done | output | 1 | A full pass has ended since reset/restart |

## Verification
The hardest case to reach from the ports is a fuse input that changes between two samplings of its slot. To show that the shadow waits a whole pass before it follows, the stimulus has to know the scan phase, and the phase is not visible at the ports. The bench keeps its own count of clock edges since the last reset or restart. It changes the trim 3 fuse in slot 10. It then checks at slot 2 of the next pass that the old value is still held, and checks one edge later that the new value has been taken. The restart case is handled the same way: the trim 1 fuse is changed just before the restart, so the edge after the restart has to reload it.

// File: rtl/trim_scan.sv
module trim_scan #(
  parameter int NUM_TRIMS = 7,
  parameter int TRIM_W    = 8,
  parameter int PASS_LEN  = 45,
  parameter int SEL_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restart,
  input  logic [NUM_TRIMS*TRIM_W-1:0] fuse_vals,
  input  logic                        sel_we,
  input  logic [SEL_W-1:0]            sel_wdata,
  output logic [SEL_W-1:0]            sel_q,
  output logic [TRIM_W-1:0]           rd_data,
  output logic [NUM_TRIMS*TRIM_W-1:0] trim_out,
  output logic                        pass_done
);
  localparam int CNT_W = $clog2(PASS_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PASS_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic [TRIM_W-1:0] shadow [NUM_TRIMS];
  logic              wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pass_done <= 1'b0;
    else if (wrap)      pass_done <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;
  end

  for (genvar k = 0; k < NUM_TRIMS; k++) begin : g_trim
    always_ff @(posedge clk) begin
      if (rst)
        shadow[k] <= '0;
      else if (!restart && cnt == CNT_W'(k))
        shadow[k] <= fuse_vals[k*TRIM_W +: TRIM_W];
    end
    assign trim_out[k*TRIM_W +: TRIM_W] = shadow[k];

    // R3: a shadow only moves in its own slot
    a_r3_hold_outside_slot: assert property (@(posedge clk) disable iff (rst)
      (restart || cnt != CNT_W'(k)) |=> $stable(shadow[k]));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_TRIMS; k++)
      if (sel_q == SEL_W'(k + 1)) rd_data = shadow[k];
  end

  // R7: flag only rises at the end of a full pass
  a_r7_done_at_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_done) |-> $past(cnt) == LAST);

  // R7: flag stays high until restart
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (pass_done && !restart) |=> pass_done);

  // R8: restart clears flag and rewinds scan
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!pass_done && cnt == '0));

  // R5: select register captures write data
  a_r5_sel_write: assert property (@(posedge clk) disable iff (rst)
    sel_we |=> sel_q == $past(sel_wdata));

  // R2: scan counter stays inside the pass
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: tb/sim_trim_scan.sv
module sim_trim_scan;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 7;
  localparam int PL = 45;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic [55:0] fuse_vals;
  logic        sel_we = 1'b0;
  logic [3:0]  sel_wdata = '0;
  logic [3:0]  sel_q;
  logic [7:0]  rd_data;
  logic [55:0] trim_out;
  logic        pass_done;

  logic [7:0] fz [1:7];
  int compared = 0;
  int mismatched = 0;
  int ph = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int k = 1; k <= NT; k++) fuse_vals[8*k-1 -: 8] = fz[k];

  trim_scan u0 (
    .clk(clk), .rst(rst), .restart(restart), .fuse_vals(fuse_vals),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q),
    .rd_data(rd_data), .trim_out(trim_out), .pass_done(pass_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tr(input int k);
    return trim_out[8*k-1 -: 8];
  endfunction

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    ph = (ph + n) % PL;
  endtask

  task automatic t_reset();
    for (int k = 1; k <= NT; k++) fz[k] = 8'(8'h21 * k + 8'h05);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(trim_out == '0, "R1 trim_out", int'(trim_out[31:0]), 0);
    chk(pass_done == 1'b0, "R1 pass_done", pass_done, 0);
    chk(sel_q == '0, "R1 sel_q", sel_q, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    rst = 1'b0;
    ph = 0;
  endtask

  task automatic t_first_pass();
    adv(1);
    chk(tr(1) == fz[1], "R2 trim1 after first edge", tr(1), fz[1]);
    chk(tr(2) == 8'h00, "R2 trim2 not yet loaded", tr(2), 0);
    adv(6);
    for (int k = 1; k <= NT; k++)
      chk(tr(k) == fz[k], "R4 trim slice after slot", tr(k), fz[k]);
    adv(37);
    chk(pass_done == 1'b0, "R7 done low at edge 44", pass_done, 0);
    adv(1);
    chk(pass_done == 1'b1, "R7 done high at edge 45", pass_done, 1);
  endtask

  task automatic t_hold();
    logic [7:0] old3;
    old3 = fz[3];
    adv(10);
    fz[3] = 8'hC3;
    adv(37);
    chk(tr(3) == old3, "R3 trim3 held until its slot", tr(3), old3);
    chk(tr(4) == fz[4], "R3 trim4 untouched", tr(4), fz[4]);
    adv(1);
    chk(tr(3) == 8'hC3, "R3 trim3 taken in its slot", tr(3), 8'hC3);
    chk(pass_done == 1'b1, "R7 done stays high", pass_done, 1);
  endtask

  task automatic wr_sel(input logic [3:0] v);
    sel_we = 1'b1;
    sel_wdata = v;
    @(posedge clk);
    @(negedge clk);
    sel_we = 1'b0;
    ph = (ph + 1) % PL;
  endtask

  task automatic t_select();
    for (int k = 1; k <= NT; k++) begin
      wr_sel(4'(k));
      chk(sel_q == 4'(k), "R5 sel_q written", sel_q, k);
      chk(rd_data == fz[k], "R5 rd_data selected trim", rd_data, fz[k]);
    end
    wr_sel(4'd0);
    chk(rd_data == 8'h00, "R6 select 0 reads zero", rd_data, 0);
    wr_sel(4'd9);
    chk(rd_data == 8'h00, "R6 select 9 reads zero", rd_data, 0);
    wr_sel(4'd15);
    chk(rd_data == 8'h00, "R6 select 15 reads zero", rd_data, 0);
  endtask

  task automatic t_restart();
    logic [7:0] old1;
    old1 = fz[1];
    fz[1] = 8'h5A;
    restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    ph = 0;
    chk(pass_done == 1'b0, "R8 restart clears done", pass_done, 0);
    chk(tr(1) == old1, "R8 shadow kept over restart", tr(1), old1);
    chk(tr(5) == fz[5], "R8 other shadow kept", tr(5), fz[5]);
    adv(1);
    chk(tr(1) == 8'h5A, "R8 first edge reloads trim1", tr(1), 8'h5A);
    adv(43);
    chk(pass_done == 1'b0, "R8 done low before pass end", pass_done, 0);
    adv(1);
    chk(pass_done == 1'b1, "R7 done after restarted pass", pass_done, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_pass();
    t_hold();
    t_select();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule